// File: doc/BRIEF.md
# Dual-Mode Control Register for a Two-Channel Device

This block sets the shared gain and cutoff codes for a device with two matched channels. One code of each kind drives both channels together. A mode input chooses where the codes come from. When it is high, four static pins supply a 2-bit gain code and a 2-bit cutoff code directly. When it is low, three of those pins change role. The cutoff high pin becomes an active-low chip select. The cutoff low pin becomes a serial clock. The gain low pin is released so that it can carry serial data out. The board is expected to hold the mode input high when nothing drives it.

In serial mode, an 8-bit shift register takes data in most significant bit first while the select is low. It is copied into an 8-bit control latch when the select rises. The latch holds the cutoff code in bits [7:6] and the gain code in bits [5:4]. Bits [3:0] are reserved and are stored unchanged. Serial data out always carries the bit that is about to leave the shift register, so several devices can share select and clock in a daisy chain.

The select and serial clock are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. The serial clock therefore has to run well below the system clock: each level must last at least three system clocks.

Top module: `dual_ctrl_reg`

## Requirements
- R1: With the mode input high, the gain code equals {gain high pin, gain low pin} and the cutoff code equals {cutoff high pin, cutoff low pin}. Both are registered and appear one system clock after the pins.
- R2: With the mode input low, the cutoff code equals latch bits [7:6] and the gain code equals latch bits [5:4], registered one system clock after the latch.
- R3: In serial mode with the select low, each detected rising edge of the serial clock shifts the shift register one place toward its most significant bit and loads the serial data input into bit 0.
- R4: A detected rising edge of the select in serial mode copies all 8 shift-register bits into the latch. A frame of fewer than 8 clocks latches the partly shifted contents. The latch changes at no other time.
- R5: Serial clock edges while the select is high change neither the shift register nor serial data out.
- R6: Serial data out is loaded with the shift-register most significant bit at each detected falling edge of the select and at each detected falling serial-clock edge while the select is low. At all other times it holds its value, including after the select rises; it is never forced to zero.
- R7: With the mode input high, the serial data out enable is low and no pin activity changes the latch. With the mode input low, the enable is high.
- R8: A serial clock that is already high when the select falls causes no shift.
- R9: After reset, the shift register, the latch, serial data out and both codes are zero.
- R10: Reserved bits [3:0] are stored in the latch as written. The previous contents of the shift register leave on serial data out during the next frame, so two chained devices take a 16-bit frame, with the far device's byte sent first.
- R11: A change of the mode input from low to high makes the codes follow the pins from the next system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeDirect | input | 1 | High: direct pin control; low: serial control |
| pinCutHi | input | 1 | Cutoff bit 1 (direct) / active-low select (serial) |
| pinCutLo | input | 1 | Cutoff bit 0 (direct) / serial clock (serial) |
| pinGainHi | input | 1 | Gain bit 1 (direct mode) |
| pinGainLo | input | 1 | Gain bit 0 input (direct mode) |
| serDataIn | input | 1 | Serial data input |
| serDataOut | output | 1 | Serial data out, shares the gain bit 0 pad |
| serDataOutEn | output | 1 | Pad drive enable for serial data out |
| gainCode | output | 2 | Active gain code for both channels |
| cutCode | output | 2 | Active cutoff code for both channels |

## Verification
The assertions check on every cycle that the shift register, the latch and serial data out stay still without their strobes, and that the latch is untouched in direct mode. They also check that the codes track the pins in direct mode and the latch fields in serial mode, one clock later. Some behaviours depend on pin sequences and only the bench scenarios show them: most-significant-bit-first ordering, a serial clock already high at select fall, clocks while the select is high, partial frames, reserved bits returning in the next frame, and a two-device chain. The bench also runs a reference model with its own pin-history delays and compares it with all outputs on every clock.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  localparam int WORD_W   = 8;
  localparam int CODE_W   = 2;
  localparam int CUT_LSB  = 6;
  localparam int GAIN_LSB = 4;

  typedef struct packed {
    logic useDirect;  // codes taken from pins
    logic shiftEn;    // shift one serial bit in
    logic sdoLoad;    // refresh serial data out
    logic latchEn;    // copy shift register to latch
  } dcr_strobe_t;
endpackage

// File: rtl/dcr_ctrl.sv
`timescale 1ns/1ps
module dcr_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeDirect,
  input  logic               csPin,
  input  logic               sclkPin,
  output dcr_pkg::dcr_strobe_t stb
);
  logic [SYNC_STAGES-1:0] csSync;
  logic [SYNC_STAGES-1:0] sclkSync;
  logic csLast, sclkLast;
  logic csNow, sclkNow;
  logic serialMode, sclkRise, sclkFall, csFall, csRise;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
        end else begin
          csSync   <= {csSync[SYNC_STAGES-2:0], csPin};
          sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkPin};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
        end else begin
          csSync   <= csPin;
          sclkSync <= sclkPin;
        end
      end
    end
  endgenerate

  assign csNow   = csSync[SYNC_STAGES-1];
  assign sclkNow = sclkSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLast   <= 1'b1;
      sclkLast <= 1'b0;
    end else begin
      csLast   <= csNow;
      sclkLast <= sclkNow;
    end
  end

  always_comb begin
    serialMode    = !modeDirect;
    sclkRise      = sclkNow && !sclkLast;
    sclkFall      = !sclkNow && sclkLast;
    csFall        = !csNow && csLast;
    csRise        = csNow && !csLast;
    stb.useDirect = modeDirect;
    stb.shiftEn   = serialMode && !csNow && sclkRise;
    stb.sdoLoad   = serialMode && !csNow && (sclkFall || csFall);
    stb.latchEn   = serialMode && csRise;
  end
endmodule

// File: rtl/dcr_datapath.sv
`timescale 1ns/1ps
module dcr_datapath #(
  parameter int WORD_W   = dcr_pkg::WORD_W,
  parameter int CODE_W   = dcr_pkg::CODE_W,
  parameter int CUT_LSB  = dcr_pkg::CUT_LSB,
  parameter int GAIN_LSB = dcr_pkg::GAIN_LSB
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dcr_pkg::dcr_strobe_t stb,
  input  logic                 serDataIn,
  input  logic [CODE_W-1:0]    pinGain,
  input  logic [CODE_W-1:0]    pinCut,
  output logic [CODE_W-1:0]    gainCode,
  output logic [CODE_W-1:0]    cutCode,
  output logic                 serDataOut
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] latchWord;
  logic              sdoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      latchWord <= '0;
      sdoReg    <= 1'b0;
    end else begin
      if (stb.shiftEn) shiftReg  <= {shiftReg[MSB-1:0], serDataIn};
      if (stb.sdoLoad) sdoReg    <= shiftReg[MSB];
      if (stb.latchEn) latchWord <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainCode <= '0;
      cutCode  <= '0;
    end else if (stb.useDirect) begin
      gainCode <= pinGain;
      cutCode  <= pinCut;
    end else begin
      gainCode <= latchWord[GAIN_LSB +: CODE_W];
      cutCode  <= latchWord[CUT_LSB +: CODE_W];
    end
  end

  assign serDataOut = sdoReg;

  // R3: the shift register moves only on a shift strobe
  a_r3_shift_only_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftEn |=> $stable(shiftReg));
  // R4: the latch moves only on a latch strobe
  a_r4_latch_only_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchEn |=> $stable(latchWord));
  // R6: serial data out holds between its load strobes
  a_r6_sdo_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sdoLoad |=> $stable(sdoReg));
  // R7: direct mode leaves the latch untouched
  a_r7_latch_kept_direct: assert property (@(posedge clk) disable iff (!rstN)
    stb.useDirect |=> $stable(latchWord));
  // R2: serial mode codes come from the latch fields
  a_r2_codes_from_latch: assert property (@(posedge clk) disable iff (!rstN)
    !stb.useDirect |=> (gainCode == $past(latchWord[GAIN_LSB +: CODE_W]))
                    && (cutCode == $past(latchWord[CUT_LSB +: CODE_W])));
endmodule

// File: rtl/dual_ctrl_reg.sv
`timescale 1ns/1ps
module dual_ctrl_reg #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = dcr_pkg::WORD_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeDirect,
  input  logic       pinCutHi,
  input  logic       pinCutLo,
  input  logic       pinGainHi,
  input  logic       pinGainLo,
  input  logic       serDataIn,
  output logic       serDataOut,
  output logic       serDataOutEn,
  output logic [1:0] gainCode,
  output logic [1:0] cutCode
);
  dcr_pkg::dcr_strobe_t stb;

  dcr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeDirect (modeDirect),
    .csPin      (pinCutHi),
    .sclkPin    (pinCutLo),
    .stb        (stb)
  );

  dcr_datapath #(.WORD_W(WORD_W), .CODE_W(2)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .serDataIn  (serDataIn),
    .pinGain    ({pinGainHi, pinGainLo}),
    .pinCut     ({pinCutHi, pinCutLo}),
    .gainCode   (gainCode),
    .cutCode    (cutCode),
    .serDataOut (serDataOut)
  );

  assign serDataOutEn = !modeDirect;

  // R1: direct mode codes follow the pins one clock later
  a_r1_direct_follow: assert property (@(posedge clk) disable iff (!rstN)
    modeDirect |=> (gainCode == $past({pinGainHi, pinGainLo}))
                && (cutCode == $past({pinCutHi, pinCutLo})));
endmodule

// File: tb/dual_ctrl_reg_bench.sv
`timescale 1ns/1ps
module dual_ctrl_reg_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode = 1'b1;
  logic csPin = 1'b1, sclkPin = 1'b0, gainHi = 1'b0, gainLo = 1'b0, sdiPin = 1'b0;
  logic sdoOut, sdoEn, sdo2, sdoEn2;
  logic [1:0] gainCode, cutCode, gain2, cut2;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_ctrl_reg u_dual_ctrl_reg (
    .clk(clk), .rstN(rstN), .modeDirect(mode), .pinCutHi(csPin), .pinCutLo(sclkPin),
    .pinGainHi(gainHi), .pinGainLo(gainLo), .serDataIn(sdiPin), .serDataOut(sdoOut),
    .serDataOutEn(sdoEn), .gainCode(gainCode), .cutCode(cutCode));

  dual_ctrl_reg u_dual_ctrl_reg_tail (
    .clk(clk), .rstN(rstN), .modeDirect(mode), .pinCutHi(csPin), .pinCutLo(sclkPin),
    .pinGainHi(1'b0), .pinGainLo(1'b0), .serDataIn(sdoOut), .serDataOut(sdo2),
    .serDataOutEn(sdoEn2), .gainCode(gain2), .cutCode(cut2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: pin histories stand for the two-clock synchroniser delay
  logic [7:0] mSh, mLatch;
  logic mSdo;
  logic [1:0] mGain, mCut;
  logic cs1, cs2, cs3, sk1, sk2, sk3;
  always @(posedge clk) begin
    logic ser, doShift, doSdo, doLatch;
    logic [1:0] nG, nC;
    if (!rstN) begin
      mSh = 0; mLatch = 0; mSdo = 0; mGain = 0; mCut = 0;
      cs1 = 1; cs2 = 1; cs3 = 1; sk1 = 0; sk2 = 0; sk3 = 0;
    end else begin
      ser     = !mode;
      doShift = ser && !cs2 && sk2 && !sk3;
      doSdo   = ser && !cs2 && ((!sk2 && sk3) || cs3);
      doLatch = ser && cs2 && !cs3;
      nG = mode ? {gainHi, gainLo} : mLatch[5:4];
      nC = mode ? {csPin, sclkPin} : mLatch[7:6];
      if (doSdo) mSdo = mSh[7];
      if (doLatch) mLatch = mSh;
      if (doShift) mSh = {mSh[6:0], sdiPin};
      mGain = nG; mCut = nC;
      cs3 = cs2; cs2 = cs1; cs1 = csPin;
      sk3 = sk2; sk2 = sk1; sk1 = sclkPin;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done)
      chk({gainCode, cutCode, sdoOut, sdoEn} === {mGain, mCut, mSdo, !mode},
          "cycle model R2 R6 R7", {gainCode, cutCode, sdoOut, sdoEn},
          {mGain, mCut, mSdo, !mode});
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBits(input logic [15:0] data, input int n, output logic [15:0] seen);
    seen = '0;
    csPin = 0; tick(H);
    for (int i = n - 1; i >= 0; i--) begin
      sdiPin = data[i];
      seen[i] = sdoOut;
      tick(H); sclkPin = 1; tick(H); sclkPin = 0; tick(H);
    end
    csPin = 1; tick(H + 2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    tick(4); rstN = 1; tick(1);
    mode = 0; tick(3);
    // R9: reset state seen in serial mode
    chk(gainCode == 0 && cutCode == 0, "R9 reset codes", {gainCode, cutCode}, 0);
    chk(sdoOut == 0 && sdoEn == 1, "R9 reset sdo", {sdoOut, sdoEn}, 1);

    // R2 R3 R4: full frame 0x96 -> cutoff 2, gain 1
    sendBits(16'h0096, 8, seen);
    chk(seen[7:0] == 8'h00, "R6 sdo shows old register", seen[7:0], 0);
    chk(cutCode == 2 && gainCode == 1, "R2 R3 R4 frame 0x96", {cutCode, gainCode}, 4'h9);

    // R10: next frame returns 0x96 including reserved nibble
    sendBits(16'h005A, 8, seen);
    chk(seen[7:0] == 8'h96, "R10 previous byte shifted out", seen[7:0], 8'h96);
    chk(seen[3:0] == 4'h6, "R10 reserved bits kept", seen[3:0], 6);
    chk(cutCode == 1 && gainCode == 1, "R2 frame 0x5A", {cutCode, gainCode}, 4'h5);
    chk(sdoOut == 0 && sdoEn == 1, "R6 sdo held after select rise", {sdoOut, sdoEn}, 1);

    // R5: clocks while select high
    sdiPin = 1;
    for (int k = 0; k < 3; k++) begin
      sclkPin = 1; tick(H); sclkPin = 0; tick(H);
    end
    chk(sdoOut == 0, "R5 sdo unchanged with select high", sdoOut, 0);
    chk(cutCode == 1 && gainCode == 1, "R5 latch unchanged with select high",
        {cutCode, gainCode}, 4'h5);
    // R8: serial clock already high when select falls
    sclkPin = 1; tick(H);
    sdiPin = 0; csPin = 0; tick(H);
    chk(sdoOut == 0, "R8 R6 preload MSB without extra shift", sdoOut, 0);
    sclkPin = 0; tick(H);
    seen = '0;
    for (int i = 3; i >= 0; i--) begin
      sdiPin = 1;
      seen[i] = sdoOut;
      tick(H); sclkPin = 1; tick(H); sclkPin = 0; tick(H);
    end
    csPin = 1; tick(H + 2);
    chk(seen[3:0] == 4'h5, "R6 R8 sdo over partial frame", seen[3:0], 5);
    chk(cutCode == 2 && gainCode == 2, "R4 R5 R8 partial frame latch 0xAF",
        {cutCode, gainCode}, 4'hA);

    // R11 R1: switch to direct mode
    gainHi = 1; gainLo = 1; csPin = 1; sclkPin = 0; mode = 1;
    tick(1);
    chk(cutCode == 2 && gainCode == 3, "R11 codes follow pins next clock",
        {cutCode, gainCode}, 4'hB);
    chk(sdoEn == 0, "R7 enable low in direct mode", sdoEn, 0);
    for (int p = 0; p < 16; p++) begin
      {csPin, sclkPin, gainHi, gainLo} = p[3:0];
      tick(1);
      chk({cutCode, gainCode} == p[3:0], "R1 direct pattern", {cutCode, gainCode}, p);
    end
    csPin = 1; sclkPin = 0; tick(5);
    mode = 0; tick(2);
    chk(cutCode == 2 && gainCode == 2 && sdoEn == 1, "R7 latch untouched by direct pins",
        {cutCode, gainCode, sdoEn}, 5'h15);

    // R10: two-device chain, far device byte first
    sendBits(16'h3C81, 16, seen);
    chk(seen[15:8] == 8'hAF, "R10 chain head old byte out", seen[15:8], 8'hAF);
    chk(seen[7:0] == 8'h3C, "R10 chain forwarded byte", seen[7:0], 8'h3C);
    chk(cutCode == 2 && gainCode == 0, "R10 near device 0x81", {cutCode, gainCode}, 4'h8);
    chk(cut2 == 0 && gain2 == 3, "R10 far device 0x3C", {cut2, gain2}, 4'h3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule